// File: doc/BRIEF.md
# Dynamic Clock Source Switcher

This block produces a system clock from one of two free-running source clocks: a crystal-derived clock and an external frequency input. A single select level chooses the source. The select may change while the system runs. The switch-over follows a fixed handshake. The clock owning the output samples the select only at moments when both the system clock and the peripheral clock are high. It then counts two falling edges of the peripheral clock and parks the output low on its own falling edge. Ownership then passes to the other source through a synchronizer clocked by that source. The new source opens its gate at a fixed edge count. As a result, the output never carries a shortened high phase, and the stretch always lands in the low part of a cycle.

The peripheral clock is an input here, a divide-by-two of the system clock produced elsewhere. It only qualifies the select sampling and times the freeze. A switching flag reports the interval from the sampling of a changed select until the new source drives the output. An asynchronous active-low reset closes both gates. After release the crystal source takes the output first. If the select then asks for the external input, a normal switch follows.

Top module: `clk_source_switcher`

## Requirements
- R1: Select level 0 routes the crystal clock to the system clock and level 1 routes the external input; once a switch completes, the system clock period equals the period of the selected source.
- R2: While reset is low the system clock is held low and the switching flag is high; after release the crystal source drives the output, whose first rising edge is the crystal rising edge that follows the first crystal falling edge after release.
- R3: The select is looked at only on falling edges of the system clock at which the peripheral clock is high; after the first such sample that sees a changed level, the system clock freezes low on its third following falling edge, which is the falling edge at which the second peripheral-clock fall has been seen, so the freeze lands within 4 output cycles of that sample.
- R4: When switching to the crystal, the first output rising edge after the freeze is the crystal rising edge that follows the second crystal falling edge after the freeze.
- R5: When switching to the external input, its gate opens on the external falling edge that follows the second external rising edge after the freeze, and the first output rising edge is the next external rising edge.
- R6: Every system clock high pulse lasts exactly one half period of one source and every low pulse lasts at least the shorter half period; the two sources never drive the output together.
- R7: The switching flag is high from the sample that sees a changed select until the new source's gate opens, and low while a source runs with a matching select.
- R8: A select change made while a switch is in progress is held: the switch completes, the new source produces pulses, and a second switch then follows the R3 to R5 timing.
- R9: A select pulse that starts and ends between two qualifying samples has no effect: the output keeps its period and the flag stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xtalClk | input | 1 | Crystal-derived source clock |
| extClk | input | 1 | External frequency source clock |
| selExt | input | 1 | Source select: 0 crystal, 1 external |
| pclk | input | 1 | Peripheral clock (system clock divided by two), qualifies sampling and times the freeze |
| rstN | input | 1 | Asynchronous reset, active low |
| sysClk | output | 1 | Glitch-free system clock |
| switching | output | 1 | High while a source change is in progress |

## Verification
The two sources run at unrelated periods, 10 ns and 26 ns, with a fractional phase offset, so the handover crosses real asynchronous edges in both directions. Random select changes at random offsets from the qualifying samples check that the freeze moment and both restart rules follow the edge counts, independent of where the change falls. Directed cases cover the corner conditions. A select flip during the frozen gap separates held changes from dropped or racing ones. Short select pulses between samples, on both sources, separate true qualified sampling from level sensing. Reset is applied both at start and while the external source runs, which shows that restart always goes through the crystal. A monitor measures every output pulse, so any overlap of the two sources or truncated phase shows up as a wrong width.

// File: rtl/clksw_pkg.sv
`timescale 1ns/10ps
package clksw_pkg;
  localparam int NUM_SRC = 2;

  // strobes from the sequencing lanes to the output gate
  typedef struct packed {
    logic [NUM_SRC-1:0] laneOpen;   // gate of source i passes its clock
    logic [NUM_SRC-1:0] laneDrain;  // source i is counting towards its freeze
  } gate_strobe_t;
endpackage

// File: rtl/clksw_lane.sv
`timescale 1ns/10ps
// One source lane: owns or waits for the output token, samples select while
// owning, counts peripheral-clock falls and releases the token on freeze.
module clksw_lane #(
  parameter int LANE_ID      = 0,
  parameter bit SYNC_ON_RISE = 1'b0,
  parameter int FREEZE_FALLS = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic srcClk,
  input  logic rstN,
  input  logic selExt,
  input  logic pclk,
  input  logic peerTok,
  output logic tokOut,
  output logic laneOpen,
  output logic laneDrain
);
  localparam bit MY_SEL = (LANE_ID != 0);
  localparam int CW = (FREEZE_FALLS > 1) ? $clog2(FREEZE_FALLS) : 1;
  localparam logic [CW-1:0] LAST_FALL = CW'(FREEZE_FALLS - 1);

  logic peerTokSync;
  logic pclkPrev;
  logic [CW-1:0] fallCnt;
  logic ownsToken;
  logic pclkFall;

  generate
    if (SYNC_ON_RISE) begin : g_rise_sync
      // full synchronizer on rising edges, gate opens on the next falling edge
      localparam int N = SYNC_STAGES;
      logic [N-1:0] chain;
      always_ff @(posedge srcClk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else begin
          chain[0] <= peerTok;
          for (int k = 1; k < N; k++) chain[k] <= chain[k-1];
        end
      end
      assign peerTokSync = chain[N-1];
    end else begin : g_fall_sync
      // the open flop itself is the last synchronizer stage
      localparam int N = SYNC_STAGES - 1;
      logic [N-1:0] chain;
      always_ff @(negedge srcClk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else begin
          chain[0] <= peerTok;
          for (int k = 1; k < N; k++) chain[k] <= chain[k-1];
        end
      end
      assign peerTokSync = chain[N-1];
    end
  endgenerate

  // two-lane token ring: lane 0 owns on equal tokens, lane 1 on different
  always_comb begin
    if (LANE_ID == 0) ownsToken = (tokOut == peerTokSync);
    else              ownsToken = (tokOut != peerTokSync);
  end

  assign pclkFall = pclkPrev & ~pclk;

  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) begin
      laneOpen  <= 1'b0;
      laneDrain <= 1'b0;
      tokOut    <= 1'b0;
      fallCnt   <= '0;
      pclkPrev  <= 1'b0;
    end else begin
      pclkPrev <= pclk;
      if (!laneOpen) begin
        if (ownsToken) laneOpen <= 1'b1;
      end else if (!laneDrain) begin
        if (pclk && (selExt != MY_SEL)) begin
          laneDrain <= 1'b1;
          fallCnt   <= '0;
        end
      end else if (pclkFall) begin
        if (fallCnt == LAST_FALL) begin
          laneOpen  <= 1'b0;
          laneDrain <= 1'b0;
          tokOut    <= ~tokOut;
          fallCnt   <= '0;
        end else begin
          fallCnt <= CW'(fallCnt + 1'b1);
        end
      end
    end
  end

  // R6: the gate may only move while its own clock is low
  always @(laneOpen) begin
    if (rstN) begin
      a_r6_gate_moves_in_low: assert (!srcClk);
    end
  end

  // R3: a drain starts only at a sample where the peripheral clock was high
  a_r3_sample_when_pclk_high: assert property (
    @(negedge srcClk) disable iff (!rstN) $rose(laneDrain) |-> pclkPrev);

  // R3: draining happens only on the lane that drives the output
  a_r3_drain_only_when_open: assert property (
    @(negedge srcClk) disable iff (!rstN) laneDrain |-> laneOpen);

  // R6: closing the gate always hands the token on
  a_r6_release_passes_token: assert property (
    @(negedge srcClk) disable iff (!rstN) $fell(laneOpen) |-> (tokOut != $past(tokOut)));
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/10ps
// Control: the two source lanes and their token crossing.
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int FREEZE_FALLS = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               rstN,
  input  logic               selExt,
  input  logic               pclk,
  output gate_strobe_t       strobes
);
  logic [NUM_SRC-1:0] tokVec;
  logic [NUM_SRC-1:0] openVec;
  logic [NUM_SRC-1:0] drainVec;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
      clksw_lane #(
        .LANE_ID      (i),
        .SYNC_ON_RISE (i == 1),
        .FREEZE_FALLS (FREEZE_FALLS),
        .SYNC_STAGES  (SYNC_STAGES)
      ) u_lane (
        .srcClk    (srcClk[i]),
        .rstN      (rstN),
        .selExt    (selExt),
        .pclk      (pclk),
        .peerTok   (tokVec[NUM_SRC-1-i]),
        .tokOut    (tokVec[i]),
        .laneOpen  (openVec[i]),
        .laneDrain (drainVec[i])
      );
    end
  endgenerate

  always_comb begin
    strobes.laneOpen  = openVec;
    strobes.laneDrain = drainVec;
  end
endmodule

// File: rtl/clksw_gate.sv
`timescale 1ns/10ps
// Datapath: per-source AND gates merged into the system clock.
module clksw_gate
  import clksw_pkg::*;
(
  input  logic [NUM_SRC-1:0] srcClk,
  input  gate_strobe_t       strobes,
  output logic               sysClk,
  output logic               switching
);
  logic [NUM_SRC-1:0] gated;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_and
      assign gated[i] = srcClk[i] & strobes.laneOpen[i];
    end
  endgenerate

  assign sysClk    = |gated;
  assign switching = (|strobes.laneDrain) | ~(|strobes.laneOpen);

  // R6: never two sources on the output at once
  always_comb begin
    a_r6_single_source: assert ($countones(strobes.laneOpen) <= 1);
  end
endmodule

// File: rtl/clk_source_switcher.sv
`timescale 1ns/10ps
module clk_source_switcher
  import clksw_pkg::*;
#(
  parameter int FREEZE_FALLS = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic xtalClk,
  input  logic extClk,
  input  logic selExt,
  input  logic pclk,
  input  logic rstN,
  output logic sysClk,
  output logic switching
);
  logic [NUM_SRC-1:0] srcClk;
  gate_strobe_t       strobes;

  assign srcClk = {extClk, xtalClk};

  clksw_ctrl #(
    .FREEZE_FALLS (FREEZE_FALLS),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_ctrl (
    .srcClk  (srcClk),
    .rstN    (rstN),
    .selExt  (selExt),
    .pclk    (pclk),
    .strobes (strobes)
  );

  clksw_gate u_gate (
    .srcClk    (srcClk),
    .strobes   (strobes),
    .sysClk    (sysClk),
    .switching (switching)
  );
endmodule

// File: tb/clk_source_switcher_tb.sv
`timescale 1ns/10ps
module clk_source_switcher_tb;
  localparam real HALF_X = 5.0;    // crystal: 100 MHz
  localparam real HALF_E = 13.0;   // external: unrelated period
  localparam real TOL    = 0.01;

  logic xtalClk = 1'b0;
  logic extClk  = 1'b0;
  logic selExt  = 1'b0;
  logic pclk    = 1'b0;
  logic rstN    = 1'b0;
  logic sysClk;
  logic switching;

  int  nChk = 0;
  int  nErr = 0;
  bit  finished = 1'b0;
  bit  monOn = 1'b0;
  bit  cur = 1'b0;
  real tRise = 0.0;
  real tFall = 0.0;
  int  riseCount = 0;

  clk_source_switcher u_dut (
    .xtalClk   (xtalClk),
    .extClk    (extClk),
    .selExt    (selExt),
    .pclk      (pclk),
    .rstN      (rstN),
    .sysClk    (sysClk),
    .switching (switching)
  );

  initial forever #(HALF_X) xtalClk = ~xtalClk;
  initial begin
    #0.3;
    forever #(HALF_E) extClk = ~extClk;
  end

  // peripheral clock: system clock divided by two
  always @(posedge sysClk or negedge rstN) begin
    if (!rstN) pclk <= 1'b0;
    else       pclk <= ~pclk;
  end

  function automatic real rabs(real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic chk(bit ok, string tag, string what, real act, real exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", tag, what, act, exp);
    end
  endtask

  // R6 pulse monitor
  always @(posedge sysClk) begin
    if (monOn && tFall > 0.0)
      chk(($realtime - tFall) >= HALF_X - TOL, "R6", "low width", $realtime - tFall, HALF_X);
    tRise = $realtime;
    riseCount++;
  end
  always @(negedge sysClk) begin
    if (monOn && tRise > 0.0)
      chk((rabs($realtime - tRise - HALF_X) < TOL) || (rabs($realtime - tRise - HALF_E) < TOL),
          "R6", "high width", $realtime - tRise, HALF_X);
    tFall = $realtime;
  end

  task automatic setSel(bit v, int unsigned d);
    @(posedge xtalClk);
    #(d + 0.7);
    selExt = v;
  endtask

  task automatic measurePeriod(bit src, string tag);
    real t1, t2, per;
    per = src ? 2.0 * HALF_E : 2.0 * HALF_X;
    @(posedge sysClk); t1 = $realtime;
    @(posedge sysClk); t2 = $realtime;
    chk(rabs(t2 - t1 - per) < TOL, tag, "output period", t2 - t1, per);
  endtask

  task automatic followSwitch(bit target, bit measure, bit flip);
    real tDet, tf, tExp, oldPer;
    int  rc0;
    oldPer = target ? 2.0 * HALF_X : 2.0 * HALF_E;
    do @(negedge sysClk); while (!pclk);
    tDet = $realtime;
    #0.05;
    chk(switching == 1'b1, "R7", "flag after qualifying sample", real'(switching), 1.0);
    repeat (3) @(negedge sysClk);
    tf = $realtime;
    rc0 = riseCount;
    chk(rabs(tf - tDet - 3.0 * oldPer) < TOL, "R3", "freeze time after sample", tf - tDet, 3.0 * oldPer);
    if (flip) begin
      fork
        begin #1.2; selExt = ~selExt; end
      join_none
    end
    if (!target) begin
      repeat (2) @(negedge xtalClk);
      @(posedge xtalClk);
    end else begin
      repeat (2) @(posedge extClk);
      @(negedge extClk);
      @(posedge extClk);
    end
    tExp = $realtime;
    #0.05;
    chk(riseCount == rc0 + 1, target ? "R5" : "R4", "single restart rise", real'(riseCount - rc0), 1.0);
    chk(rabs(tRise - tExp) < TOL, target ? "R5" : "R4", "restart edge time", tRise, tExp);
    chk(switching == 1'b0, "R7", "flag after restart", real'(switching), 0.0);
    if (measure) measurePeriod(target, "R1");
  endtask

  task automatic ignorePulse();
    real tA, tB, per;
    per = cur ? 2.0 * HALF_E : 2.0 * HALF_X;
    do @(negedge sysClk); while (!pclk);
    #0.7 selExt = ~selExt;
    #8.0 selExt = ~selExt;
    @(posedge sysClk); tA = $realtime;
    repeat (4) @(posedge sysClk);
    tB = $realtime;
    chk(rabs(tB - tA - 4.0 * per) < TOL, "R9", "period after short select pulse", tB - tA, 4.0 * per);
    #0.05;
    chk(switching == 1'b0, "R9", "flag after short select pulse", real'(switching), 0.0);
  endtask

  task automatic doReset();
    real tExp;
    monOn = 1'b0;
    @(posedge xtalClk);
    #0.7 rstN = 1'b0;
    #1.0;
    chk(sysClk == 1'b0, "R2", "clock low in reset", real'(sysClk), 0.0);
    chk(switching == 1'b1, "R2", "flag high in reset", real'(switching), 1.0);
    #31.0;
    chk(sysClk == 1'b0, "R2", "clock still low in reset", real'(sysClk), 0.0);
    selExt = 1'b0;
    cur = 1'b0;
    @(posedge xtalClk);
    #0.7;
    tRise = 0.0; tFall = 0.0; riseCount = 0;
    rstN = 1'b1;
    monOn = 1'b1;
    @(negedge xtalClk);
    @(posedge xtalClk);
    tExp = $realtime;
    #0.05;
    chk(riseCount == 1, "R2", "first rise count", real'(riseCount), 1.0);
    chk(rabs(tRise - tExp) < TOL, "R2", "first rise time", tRise, tExp);
    chk(switching == 1'b0, "R7", "flag low once crystal runs", real'(switching), 0.0);
    measurePeriod(1'b0, "R1");
  endtask

  initial begin
    bit tgt;
    void'($urandom(32'd20250));
    doReset();
    ignorePulse();
    // directed: switch to external, then back
    setSel(1'b1, 0); followSwitch(1'b1, 1'b1, 1'b0); cur = 1'b1;
    ignorePulse();
    setSel(1'b0, 7); followSwitch(1'b0, 1'b1, 1'b0); cur = 1'b0;
    // R8: select flipped back while frozen
    setSel(1'b1, 3); followSwitch(1'b1, 1'b0, 1'b1); followSwitch(1'b0, 1'b1, 1'b0); cur = 1'b0;
    // random switch points
    for (int i = 0; i < 14; i++) begin
      tgt = ~cur;
      setSel(tgt, $urandom_range(0, 40));
      followSwitch(tgt, 1'b1, 1'b0);
      cur = tgt;
      if ($urandom_range(0, 3) == 0) ignorePulse();
    end
    // R2: reset while external runs
    if (!cur) begin
      setSel(1'b1, 2); followSwitch(1'b1, 1'b1, 1'b0); cur = 1'b1;
    end
    doReset();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    #1000000.0;
    if (!finished) begin
      nChk++;
      nErr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end
endmodule